// File: doc/BRIEF.md
# Tag Compare and Fill Unit

This unit sits beside a small synchronous storage array so that the array can serve as a cache tag store. The caller issues a compare by starting a selected read cycle and presenting the tag on the write-data bus with the data enable asserted. The tag is captured in an input data register. The addressed word is then checked against it, and a match flag comes back with the same latency as read data.

When the compare misses, the caller issues a fill write to the same address with the data enable deasserted. The array then stores the tag already held in the input register, so the bus does not have to drive it again. Ordinary reads and writes still work. A mode pin selects flow-through timing (results after the edge that samples the command) or pipelined timing (one edge later) for both read data and the match flag. The match and read-data enables act without waiting for the clock.

Top module: `tag_cmp_fill`

## Requirements
- R1: After a reset edge, `match_out` is 1 and `rdata_en` is 0 in either timing mode.
- R2: The input data register takes `wdata` on an edge where `din_en` is 1. On an edge where `din_en` is 0 it keeps its value, whatever `wdata` carries.
- R3: A normal write (`sel`=1, `wr_n`=0, `din_en`=1) stores `wdata` at `addr`.
- R4: A fill write (`sel`=1, `wr_n`=0, `din_en`=0) stores the value held in the input data register at `addr`. `wdata` on that edge has no effect on the stored word.
- R5: A selected read (`sel`=1, `wr_n`=1) returns the addressed word on `rdata`, with `rdata_en` = `oe` for that result slot.
- R6: For a selected read, the match flag is 1 when all `DATA_W` bits of the addressed word, parity bits (the top two bits by default) included, equal the input register value after that edge. Otherwise it is 0.
- R7: With `flow_mode`=1, read and match results show after the edge that samples the command. With `flow_mode`=0 they show after the next edge.
- R8: A result slot from a deselected cycle or a write cycle presents `match_out` = 1.
- R9: `match_en` follows `moe` and `rdata_en` is gated by `oe` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Unit selected for this cycle |
| wr_n | input | 1 | 0 = write cycle, 1 = read cycle |
| din_en | input | 1 | Input data register load enable |
| oe | input | 1 | Read-data output enable (asynchronous) |
| moe | input | 1 | Match output enable (asynchronous) |
| flow_mode | input | 1 | 1 = flow-through, 0 = pipelined |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data / compare tag |
| rdata | output | DATA_W | Read data |
| rdata_en | output | 1 | Read data is being driven |
| match_out | output | 1 | Match flag |
| match_en | output | 1 | Match flag is being driven |

## Verification
A wrong value in the input data register stays hidden until a later compare or fill uses it. It then shows up as a wrong match flag, or as a wrong word on a later read, one or two edges after that command depending on the timing mode. A fault in the output stage shows up immediately as data or a match flag shifted by one slot. The bench therefore runs hit, miss, fill and re-compare in both modes, and then runs a random mix of cycles over a small tag pool so that hits are frequent.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
// Package: shared cycle decode for the tag compare and fill unit.
// Assumes the select, write strobe and data enable are sampled on the same edge.
package tcf_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_FILL  = 2'd3
    } op_e;

    // Classify one sampled command.
    function automatic op_e decode_op(input logic sel, input logic wr_n, input logic din_en);
        if (!sel)
            return OP_IDLE;
        else if (wr_n)
            return OP_READ;
        else if (din_en)
            return OP_WRITE;
        else
            return OP_FILL;
    endfunction

endpackage

// File: rtl/tcf_in_reg.sv
`timescale 1ns/1ps
// Module: input data register. It loads on edges with load=1 and holds otherwise.
// Assumes a synchronous active-low reset that clears the register to zero.
module tcf_in_reg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the bus value only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/tcf_array.sv
`timescale 1ns/1ps
// Module: word storage with one synchronous write port and one combinational read port.
// Assumes the storage is not reset; callers write a word before reading it.
module tcf_array #(
    parameter int W  = 18,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store the selected write data on the edge.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the word at the registered read address.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/tcf_out_stage.sv
`timescale 1ns/1ps
// Module: result stage shared by read data and the match flag.
// Flow mode passes the first-stage result straight through; pipelined mode adds one register.
// Assumes flow_mode changes only between commands.
module tcf_out_stage #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flow_mode,
    input  logic         s1_match,
    input  logic         s1_vld,
    input  logic [W-1:0] s1_data,
    output logic         out_match,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    logic         s2_match;
    logic         s2_vld;
    logic [W-1:0] s2_data;

    // Second stage for pipelined timing; the match flag idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_match <= 1'b1;
            s2_vld   <= 1'b0;
            s2_data  <= '0;
        end else begin
            s2_match <= s1_match;
            s2_vld   <= s1_vld;
            s2_data  <= s1_data;
        end
    end

    // Pick the stage that matches the timing mode.
    always_comb begin
        if (flow_mode) begin
            out_match = s1_match;
            out_vld   = s1_vld;
            out_data  = s1_data;
        end else begin
            out_match = s2_match;
            out_vld   = s2_vld;
            out_data  = s2_data;
        end
    end

endmodule

// File: rtl/tag_cmp_fill.sv
`timescale 1ns/1ps
// Module: tag compare and fill unit (top).
// Decodes read, write and fill cycles and gates the input data register with din_en.
// Compares the addressed word with the registered tag and times the results by flow_mode.
// Assumes synchronous inputs except oe and moe, which gate the outputs directly.
module tag_cmp_fill
    import tcf_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              din_en,
    input  logic              oe,
    input  logic              moe,
    input  logic              flow_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en,
    output logic              match_out,
    output logic              match_en
);

    op_e               op;
    logic [DATA_W-1:0] in_q;
    logic              arr_we;
    logic [DATA_W-1:0] arr_wdata;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [DATA_W-1:0] word;
    logic              s1_match;
    logic              out_vld;

    // Classify the command on the bus.
    always_comb op = decode_op(sel, wr_n, din_en);

    tcf_in_reg #(.W(DATA_W)) u_in_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (din_en),
        .d     (wdata),
        .q     (in_q)
    );

    // A fill writes the held tag; a normal write takes the bus.
    always_comb begin
        arr_we    = (op == OP_WRITE) || (op == OP_FILL);
        arr_wdata = (op == OP_FILL) ? in_q : wdata;
    end

    tcf_array #(.W(DATA_W), .AW(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (addr),
        .wdata (arr_wdata),
        .raddr (addr_q),
        .rdata (word)
    );

    // First result stage: register the address and whether it was a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            addr_q <= addr;
            rd_q   <= (op == OP_READ);
        end
    end

    // Full-width equality for reads; non-read slots report high.
    always_comb s1_match = rd_q ? (word == in_q) : 1'b1;

    tcf_out_stage #(.W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_mode (flow_mode),
        .s1_match  (s1_match),
        .s1_vld    (rd_q),
        .s1_data   (word),
        .out_match (match_out),
        .out_vld   (out_vld),
        .out_data  (rdata)
    );

    // Enable pins act without a clock.
    always_comb begin
        rdata_en = oe & out_vld;
        match_en = moe;
    end

endmodule

// File: rtl/tag_cmp_fill_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for tag_cmp_fill, attached by bind.
// Assumes it sees the top ports plus the input data register.
module tag_cmp_fill_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr_n,
    input logic              din_en,
    input logic              oe,
    input logic              moe,
    input logic              flow_mode,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] in_q,
    input logic              rdata_en,
    input logic              match_out,
    input logic              match_en
);

    logic [1:0] cyc;

    // Count non-reset edges, saturating, so that history checks start late enough.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc <= 2'd0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (match_out && !rdata_en));

    assert_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !$past(din_en)) |-> $stable(in_q));

    assert_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && $past(din_en)) |-> (in_q == $past(wdata)));

    assert_flow_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && flow_mode) |-> (rdata_en == (oe && $past(sel && wr_n))));

    assert_flow_idle_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && flow_mode && !$past(sel && wr_n)) |-> match_out);

    assert_pipe_idle_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && !flow_mode && !$past(sel && wr_n, 2)) |-> match_out);

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en |-> oe);

    assert_moe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_en == moe);

endmodule

bind tag_cmp_fill tag_cmp_fill_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr_n      (wr_n),
    .din_en    (din_en),
    .oe        (oe),
    .moe       (moe),
    .flow_mode (flow_mode),
    .wdata     (wdata),
    .in_q      (in_q),
    .rdata_en  (rdata_en),
    .match_out (match_out),
    .match_en  (match_en)
);

// File: tb/tb_tag_cmp_fill.sv
`timescale 1ns/1ps
// Bench: directed hit/miss/fill sequences in both timing modes, then seeded random cycles.
module tb_tag_cmp_fill;

    localparam int DW = 18;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          wr_n = 1'b1;
    logic          din_en = 1'b0;
    logic          oe = 1'b0;
    logic          moe = 1'b1;
    logic          flow_mode = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_en;
    logic          match_out;
    logic          match_en;

    int checks = 0;
    int errors = 0;

    // Bench reference state.
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_in = '0;
    logic          prev_m = 1'b1;
    logic          prev_v = 1'b0;
    logic [DW-1:0] prev_d = '0;
    logic          cur_v = 1'b0;

    always #4 clk = ~clk;

    tag_cmp_fill #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_n(wr_n), .din_en(din_en),
        .oe(oe), .moe(moe), .flow_mode(flow_mode), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_en(rdata_en), .match_out(match_out), .match_en(match_en)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected match flag for a sampled command, from R6 and R8.
    function automatic logic exp_match(input logic rd, input logic [DW-1:0] word, input logic [DW-1:0] tagv);
        return rd ? (word == tagv) : 1'b1;
    endfunction

    // Apply one command, pass one edge, update the reference and check the outputs.
    task automatic step(input logic s, input logic w, input logic de, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        logic [DW-1:0] old_in;
        logic          nv;
        logic          nm;
        logic [DW-1:0] nd;
        logic          em;
        logic          ev;
        logic [DW-1:0] ed;
        sel = s; wr_n = w; din_en = de; addr = a; wdata = d;
        @(posedge clk); #2;
        old_in = m_in;
        if (s && !w) m_mem[a] = de ? d : old_in;
        if (de) m_in = d;
        nv = s && w;
        nd = m_mem[a];
        nm = exp_match(nv, nd, m_in);
        em = flow_mode ? nm : prev_m;
        ev = flow_mode ? nv : prev_v;
        ed = flow_mode ? nd : prev_d;
        check(tag, "match_out", {31'd0, match_out}, {31'd0, em});
        check("R9", "match_en", {31'd0, match_en}, {31'd0, moe});
        check(tag, "rdata_en", {31'd0, rdata_en}, {31'd0, oe & ev});
        if (ev) check(tag, "rdata", {14'd0, rdata}, {14'd0, ed});
        cur_v = ev;
        prev_m = nm; prev_v = nv; prev_d = nd;
    endtask

    task automatic idle_step(input string tag);
        step(1'b0, 1'b1, 1'b0, '0, '0, tag);
    endtask

    // Hit, miss, fill and re-compare at one address; the held tag differs only in a parity bit.
    task automatic tag_sequence(input logic [AW-1:0] a, input logic [DW-1:0] t, input string mtag);
        logic [DW-1:0] t2;
        t2 = t ^ (18'h1 << (DW - 1));
        oe = 1'b0; moe = 1'b1;
        step(1'b1, 1'b0, 1'b1, a, t, "R3");           // normal write
        step(1'b1, 1'b1, 1'b1, a, t, "R6");           // compare hit
        step(1'b1, 1'b1, 1'b1, a, t2, "R6");          // compare miss on parity bit
        step(1'b1, 1'b0, 1'b0, a, ~t, "R4");          // fill, bus carries junk
        step(1'b1, 1'b1, 1'b1, a, t2, mtag);          // re-compare now hits
        oe = 1'b1;
        step(1'b1, 1'b1, 1'b0, a, 18'h0_0f0f, "R5");  // plain read of the filled word
        idle_step("R8");
        idle_step("R8");
    endtask

    initial begin
        logic [DW-1:0] pool [4];
        void'($urandom(32'd1234));
        pool[0] = 18'h2_1a5c; pool[1] = 18'h1_1a5c; pool[2] = 18'h0_7e01; pool[3] = 18'h3_ffff;

        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1; oe = 1'b1;
        // First edge after release: state comes from the reset edge.
        @(posedge clk); #2;
        check("R1", "match_out after reset", {31'd0, match_out}, 32'd1);
        check("R1", "rdata_en after reset", {31'd0, rdata_en}, 32'd0);
        oe = 1'b0;

        // Preload every word with a normal write.
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b0, 1'b1, AW'(i), DW'(i * 4099 + 17), "R3");

        // Flow-through: results after the sampling edge.
        flow_mode = 1'b1;
        tag_sequence(4'd3, 18'h0_5a5a, "R7");

        // R2: junk on the bus with din_en low must not disturb the held tag.
        step(1'b1, 1'b1, 1'b1, 4'd9, 18'h2_c3c3, "R2");
        idle_step("R2");
        sel = 1'b0; din_en = 1'b0; wdata = 18'h1_1111;
        step(1'b0, 1'b1, 1'b0, 4'd0, 18'h0_beef, "R2");
        step(1'b1, 1'b0, 1'b0, 4'd5, 18'h3_0000, "R2"); // fill with held tag
        oe = 1'b1;
        step(1'b1, 1'b1, 1'b0, 4'd5, 18'h0_0000, "R2");
        idle_step("R2");

        // R9: enables act between edges.
        oe = 1'b0;
        step(1'b1, 1'b1, 1'b0, 4'd5, 18'h0, "R5");
        oe = 1'b1; moe = 1'b0; #1;
        check("R9", "rdata_en without edge", {31'd0, rdata_en}, {31'd0, cur_v});
        check("R9", "match_en without edge", {31'd0, match_en}, 32'd0);
        moe = 1'b1; oe = 1'b0; #1;
        check("R9", "rdata_en gated off", {31'd0, rdata_en}, 32'd0);

        // R8: a write slot reports high.
        step(1'b1, 1'b0, 1'b1, 4'd7, 18'h0_0007, "R8");
        idle_step("R8");

        // Pipelined: results one edge later.
        flow_mode = 1'b0;
        idle_step("R7");
        tag_sequence(4'd11, 18'h1_2345, "R7");
        step(1'b1, 1'b1, 1'b1, 4'd11, 18'h0_0000, "R6");
        step(1'b1, 1'b1, 1'b1, 4'd11, 18'h0_2345 ^ 18'h1_0000 ^ 18'h1_0000 ^ 18'h2_0000, "R6");
        idle_step("R7");

        // Seeded random mix over a small tag pool.
        for (int n = 0; n < 600; n++) begin
            if (n % 64 == 63) begin
                flow_mode = ~flow_mode;
            end
            oe  = 1'($urandom % 2);
            moe = 1'($urandom % 4 != 0);
            step(1'($urandom % 5 != 0), 1'($urandom % 2), 1'($urandom % 3 != 0),
                 AW'($urandom % 4), pool[$urandom % 4], "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule